// File: doc/BRIEF.md
# Serial Bus Pause Controller

This block decides when a serial slave's command engine must freeze in the middle of a transfer. It runs in the system clock domain and watches three already-synchronized levels: the active-low chip select, the serial clock and an active-low pause request. From them it produces a registered `pause_o` for the engine and a `so_hiz_o` request that forces the serial data output to high impedance.

Entry and exit of the pause are qualified by the serial clock level. A request or a release seen while the serial clock is high is held back until the serial clock is sampled low. The output tri-state request is not qualified: it follows the pause request at once. While `pause_o` is high the engine keeps its bit counter, shift registers and state and ignores serial clock and data, so the transfer resumes at the exact bit where it stopped. Deselecting the slave clears any pause.

Top module: `hold_ctrl`

## Requirements
- R1: While `rst_n` is low, `pause_o` is 0, and `so_hiz_o` is 0 when `hold_n_i` is 1.
- R2: When selected (`cs_n_i`=0) and not paused, sampling `hold_n_i`=0 with `sck_i`=0 makes `pause_o` 1 after the next clock edge.
- R3: When not paused, sampling `hold_n_i`=0 with `sck_i`=1 keeps `pause_o` 0; the pause starts one clock after `sck_i` is first sampled 0 while `hold_n_i` is still 0.
- R4: A deferred request is withdrawn if `hold_n_i` returns to 1 before `sck_i` is sampled 0: `pause_o` stays 0.
- R5: When paused and selected, sampling `hold_n_i`=1 with `sck_i`=0 makes `pause_o` 0 after the next clock edge.
- R6: When paused, a release sampled while `sck_i`=1 keeps `pause_o` 1; it completes one clock after `sck_i` is sampled 0 if `hold_n_i` is still 1, and is cancelled if `hold_n_i` returns to 0 first.
- R7: `so_hiz_o` is 1 in the same cycle that `hold_n_i` is 0, whatever the level of `sck_i`, and is 1 whenever `pause_o` is 1; otherwise it is 0.
- R8: Sampling `cs_n_i`=1 makes `pause_o` 0 after the next clock edge from any state, and no pause is entered while deselected.
- R9: While paused with `hold_n_i`=0, toggling `sck_i` leaves `pause_o` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Synchronized chip select, active low |
| sck_i | input | 1 | Synchronized serial clock level |
| hold_n_i | input | 1 | Synchronized pause request, active low |
| pause_o | output | 1 | Freeze command to the serial engine |
| so_hiz_o | output | 1 | Force the serial data output to high impedance |

## Verification
The bench goes after the two deferred paths: a request made with the serial clock high, and a release made with the serial clock high. A design that ignored the clock level would freeze or resume the engine in the middle of a clock-high phase, and the checks would see `pause_o` change one clock early. It also withdraws a deferred request before the clock falls and cancels a pending release. A design that latched the first edge instead of the current level would pause or resume where it should not. Deselecting in every state catches a pause that survives chip select. Same-cycle checks of `so_hiz_o` catch an output that waits for the clock qualification.

// File: rtl/hold_ctrl_pkg.sv
package hold_ctrl_pkg;

    // RUN: engine runs; DEFER: request seen with SCK high;
    // PAUSE: engine frozen; RESUME_WAIT: release seen with SCK high.
    typedef enum logic [1:0] {
        ST_RUN         = 2'd0,
        ST_DEFER       = 2'd1,
        ST_PAUSE       = 2'd2,
        ST_RESUME_WAIT = 2'd3
    } hold_st_e;

    typedef struct packed {
        hold_st_e st;
    } hold_regs_t;

    function automatic logic st_is_frozen(input hold_st_e s);
        return (s == ST_PAUSE) || (s == ST_RESUME_WAIT);
    endfunction

endpackage

// File: rtl/hold_pause_fsm.sv
module hold_pause_fsm
    import hold_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sck_i,
    input  logic req_i,
    output logic pause_o
);

    hold_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!sel_i) begin
            r_d.st = ST_RUN;
        end else begin
            unique case (r_q.st)
                ST_RUN: begin
                    if (req_i) r_d.st = sck_i ? ST_DEFER : ST_PAUSE;
                end
                ST_DEFER: begin
                    if (!req_i)      r_d.st = ST_RUN;
                    else if (!sck_i) r_d.st = ST_PAUSE;
                end
                ST_PAUSE: begin
                    if (!req_i) r_d.st = sck_i ? ST_RESUME_WAIT : ST_RUN;
                end
                ST_RESUME_WAIT: begin
                    if (req_i)       r_d.st = ST_PAUSE;
                    else if (!sck_i) r_d.st = ST_RUN;
                end
                default: r_d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_RUN};
        else        r_q <= r_d;
    end

    assign pause_o = st_is_frozen(r_q.st);

    // R8: deselect always clears the pause
    p_desel_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> !pause_o);

    // R2: qualified request enters the pause
    p_enter_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && req_i && !sck_i) |=> pause_o);

    // R3: no entry while SCK high
    p_no_enter_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pause_o && sck_i) |=> !pause_o);

    // R5: qualified release resumes
    p_resume_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !req_i && !sck_i) |=> !pause_o);

    // R6: no resume while SCK high
    p_no_resume_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_o && sel_i && sck_i) |=> pause_o);

    // R9: held request keeps the pause through SCK activity
    p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_o && sel_i && req_i) |=> pause_o);

endmodule

// File: rtl/hold_so_gate.sv
module hold_so_gate (
    input  logic req_i,
    input  logic pause_i,
    output logic so_hiz_o
);

    // The tri-state request is not clock-qualified: a raw request acts at once.
    assign so_hiz_o = req_i | pause_i;

endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic hold_n_i,
    output logic pause_o,
    output logic so_hiz_o
);

    logic sel;
    logic req;

    assign sel = ~cs_n_i;
    assign req = ~hold_n_i;

    hold_pause_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel),
        .sck_i   (sck_i),
        .req_i   (req),
        .pause_o (pause_o)
    );

    hold_so_gate u_so (
        .req_i    (req),
        .pause_i  (pause_o),
        .so_hiz_o (so_hiz_o)
    );

    // R7: output floats whenever the request pin is low
    p_hiz_on_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n_i |-> so_hiz_o);

    // R7: output floats during the whole pause
    p_hiz_in_pause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_o |-> so_hiz_o);

    // R1: no pause straight out of reset
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |-> !pause_o);

endmodule

// File: tb/sim_hold_ctrl.sv
module sim_hold_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic hold_n = 1'b1;
    logic pause;
    logic so_hiz;

    int n_checks = 0;
    int n_fail = 0;
    logic exp_pause = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hold_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n),
        .sck_i    (sck),
        .hold_n_i (hold_n),
        .pause_o  (pause),
        .so_hiz_o (so_hiz)
    );

    // Expected pause after one clock edge, from the requirements.
    function automatic logic model_next(input logic p, input logic c,
                                        input logic s, input logic h);
        if (c)  return 1'b0;          // R8
        if (!p) return !h && !s;      // R2, R3, R4
        return !(h && !s);            // R5, R6, R9
    endfunction

    function automatic string model_tag(input logic p, input logic c,
                                        input logic s, input logic h);
        if (c)        return "R8";
        if (!p && !h) return s ? "R3" : "R2";
        if (!p)       return "R4";
        if (!h)       return "R9";
        return s ? "R6" : "R5";
    endfunction

    task automatic check(input logic act, input logic exp, input string tag,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic c, input logic s, input logic h);
        string tag;
        @(negedge clk);
        cs_n = c; sck = s; hold_n = h;
        #1;
        check(so_hiz, ~h | exp_pause, "R7", "so_hiz");
        tag = model_tag(exp_pause, c, s, h);
        exp_pause = model_next(exp_pause, c, s, h);
        @(posedge clk);
        #1;
        check(pause, exp_pause, tag, "pause");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pause, 1'b0, "R1", "pause in reset");
        check(so_hiz, 1'b0, "R1", "so_hiz in reset");
        hold_n = 1'b0; cs_n = 1'b0;
        @(posedge clk); #1;
        check(pause, 1'b0, "R1", "pause in reset with request");
        @(negedge clk);
        hold_n = 1'b1; cs_n = 1'b1;
        rst_n = 1'b1;

        // R2 then R9 then R6 release deferred, then R5
        step(0, 0, 1);
        step(0, 0, 0);
        step(0, 1, 0);
        step(0, 0, 0);
        step(0, 1, 0);
        step(0, 1, 1);
        step(0, 1, 1);
        step(0, 0, 1);
        // R3: deferred entry
        step(0, 1, 0);
        step(0, 1, 0);
        step(0, 0, 0);
        step(0, 0, 1);
        // R4: withdrawn deferred request
        step(0, 1, 0);
        step(0, 1, 1);
        step(0, 0, 1);
        // R6: release cancelled
        step(0, 0, 0);
        step(0, 1, 1);
        step(0, 1, 0);
        step(0, 0, 0);
        // R8: deselect clears, no entry while deselected
        step(1, 0, 0);
        step(1, 0, 0);
        step(0, 1, 0);
        step(1, 1, 0);
        step(1, 0, 1);

        for (int i = 0; i < N_RANDOM; i++) begin
            logic c, s, h;
            c = ($urandom_range(0, 15) == 0);
            s = 1'($urandom_range(0, 1));
            h = ($urandom_range(0, 2) != 0);
            step(c, s, h);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule